// File: doc/BRIEF.md
# Shared Receive Silo for an Eight-Line Serial Multiplexer

This block is the common receive queue behind eight serial receivers. Each receiver hands over a finished character as a single-cycle strobe carrying its line number, the character, and its framing, parity and break indications. The block stores the characters in arrival order in one 64-entry queue shared by all lines. Each entry is tagged with its line and its error flags. A host drains the queue through a 16-bit receive word. Every read that finds data removes exactly one entry, and a read of an empty queue returns a word with the valid bit clear.

A three-bit control word holds the scan enable, the receive interrupt enable and the alarm enable. With alarm off, the interrupt request follows "queue not empty". With alarm on, the request waits until at least 16 characters are held. This cuts the interrupt rate when traffic is heavy. A character that arrives while the queue is full is lost, and the next character that is stored is marked with the overrun flag.

Top module: `mux_rx_silo`

## Requirements
- R1: A synchronous reset empties the queue, clears all three control bits and drops the interrupt request. After reset, a receive-word read returns 0x0000.
- R2: Characters from all lines share one 64-entry queue and are read out in arrival order. A receive word that holds data has bit 15 (valid) set, the line number in bits 10:8 and the character in bits 7:0. Bit 11 reads as 0.
- R3: Each entry keeps its own error flags: parity error in bit 12 and framing error in bit 13.
- R4: A break indication is stored as character 0x00 with the framing flag (bit 13) set, whatever character value came with it. A parity flag that arrives with it is kept.
- R5: A receive-word read that returns valid data removes exactly one entry. A read of an empty queue returns valid clear and changes nothing: a character pushed afterwards is read back as the next word.
- R6: A character that arrives while all 64 entries are held is dropped. The next character that is stored carries the overrun flag in bit 14, and the characters stored after it do not.
- R7: While the scan enable (control bit 0) is clear, arriving characters are ignored: none is stored and none causes an overrun mark.
- R8: With the alarm enable (control bit 2) clear, the interrupt request is high exactly when the receive interrupt enable (control bit 1) is set and the queue holds at least one entry.
- R9: With the alarm enable set, the interrupt request is high exactly when the interrupt enable is set and at least 16 entries are held.
- R10: Register select 0 addresses the control word, which reads back its three bits in bits 2:0 with the other bits 0. Register select 1 addresses the receive word. A write to the receive word changes neither the control bits nor the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lineValid | input | 1 | One-cycle strobe: a receiver delivers a character |
| lineNum | input | 3 | Line number of the delivered character |
| lineData | input | 8 | Delivered character |
| lineFrameErr | input | 1 | Framing error on the delivered character |
| lineParityErr | input | 1 | Parity error on the delivered character |
| lineBreak | input | 1 | The delivered character is a break |
| regSel | input | 1 | Register select: 0 control word, 1 receive word |
| regWrEn | input | 1 | Host write strobe |
| regWrData | input | 3 | Host write data (control bits) |
| regRdEn | input | 1 | Host read strobe; pops the queue when the receive word is selected and data is present |
| regRdData | output | 16 | Contents of the selected register |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach is the overrun path. The queue must be full, a character must be lost, and room must then be made so that the mark lands on a later, real entry. That mark must also be cleared for the entries after it. The stimulus fills all 64 entries with numbered characters and offers one more while the queue is full. It then pops one entry and pushes a recognisable character. Draining the queue then shows the 63 untouched entries followed by the single marked one. The alarm threshold is reached the same way, by counting pushes up to one short of the level and then one past it.

// File: rtl/silo_pkg.sv
package silo_pkg;

  localparam int LINE_W  = 3;
  localparam int DATA_W  = 8;
  localparam int RD_W    = 16;
  localparam int CTRL_W  = 3;

  // Receive word layout (host software decodes these positions)
  localparam int VALID_BIT  = 15;
  localparam int OVR_BIT    = 14;
  localparam int FRAME_BIT  = 13;
  localparam int PARITY_BIT = 12;
  localparam int LINE_LSB   = 8;

  // Control word layout
  localparam int SCAN_BIT  = 0;
  localparam int IE_BIT    = 1;
  localparam int ALARM_BIT = 2;

  typedef struct packed {
    logic              ovr;
    logic              frame;
    logic              parity;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } siloEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
  } siloStrobes_t;

endpackage

// File: rtl/silo_dpath.sv
module silo_dpath
  import silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  siloStrobes_t     strb,
  input  siloEntry_t       wrEntry,
  output siloEntry_t       headEntry,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  siloEntry_t       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bumpPtr(wrPtr);
      if (strb.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign headEntry = mem[rdPtr];

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_push_room_R6: assert property (@(posedge clk) disable iff (rst)
    strb.push |-> !full);

  assert_pop_data_R5: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> !empty);

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count + 1'b1 == $past(count)));

endmodule

// File: rtl/silo_ctrl.sv
module silo_ctrl
  import silo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineValid,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [DATA_W-1:0] lineData,
  input  logic              lineFrameErr,
  input  logic              lineParityErr,
  input  logic              lineBreak,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              regRdEn,
  input  siloEntry_t        headEntry,
  input  logic [CNT_W-1:0]  count,
  input  logic              empty,
  input  logic              full,
  output siloStrobes_t      strb,
  output siloEntry_t        wrEntry,
  output logic [RD_W-1:0]   regRdData,
  output logic              rxIrq
);

  logic [CTRL_W-1:0] ctrlBits;
  logic              pendingOvr;
  logic              scanEn;
  logic              irqEn;
  logic              alarmEn;
  logic              arrive;
  logic              dropChar;

  assign scanEn  = ctrlBits[SCAN_BIT];
  assign irqEn   = ctrlBits[IE_BIT];
  assign alarmEn = ctrlBits[ALARM_BIT];

  assign arrive   = lineValid && scanEn;
  assign dropChar = arrive && full;

  always_comb begin
    strb      = '0;
    strb.push = arrive && !full;
    strb.pop  = regRdEn && regSel && !empty;
  end

  always_comb begin
    wrEntry        = '0;
    wrEntry.ovr    = pendingOvr;
    wrEntry.frame  = lineFrameErr || lineBreak;
    wrEntry.parity = lineParityErr;
    wrEntry.line   = lineNum;
    wrEntry.data   = lineBreak ? '0 : lineData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlBits   <= '0;
      pendingOvr <= 1'b0;
    end else begin
      if (regWrEn && !regSel) ctrlBits <= regWrData;
      if (dropChar)           pendingOvr <= 1'b1;
      else if (strb.push)     pendingOvr <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regSel) begin
      regRdData[CTRL_W-1:0] = ctrlBits;
    end else if (!empty) begin
      regRdData[VALID_BIT]                 = 1'b1;
      regRdData[OVR_BIT]                   = headEntry.ovr;
      regRdData[FRAME_BIT]                 = headEntry.frame;
      regRdData[PARITY_BIT]                = headEntry.parity;
      regRdData[LINE_LSB +: LINE_W]        = headEntry.line;
      regRdData[DATA_W-1:0]                = headEntry.data;
    end
  end

  assign rxIrq = irqEn && (alarmEn ? (count >= CNT_W'(ALARM_LEVEL)) : !empty);

  assert_drop_marks_R6: assert property (@(posedge clk) disable iff (rst)
    (lineValid && scanEn && full) |=> pendingOvr);

  assert_scan_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!scanEn && !regWrEn) |=> count <= $past(count));

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rxIrq);

  assert_alarm_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (alarmEn && count < CNT_W'(ALARM_LEVEL)) |-> !rxIrq);

endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import silo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineValid,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [DATA_W-1:0] lineData,
  input  logic              lineFrameErr,
  input  logic              lineParityErr,
  input  logic              lineBreak,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [RD_W-1:0]   regRdData,
  output logic              rxIrq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  siloStrobes_t     strb;
  siloEntry_t       wrEntry;
  siloEntry_t       headEntry;
  logic [CNT_W-1:0] count;
  logic             empty;
  logic             full;

  silo_ctrl #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_ctrl (
    .clk(clk), .rst(rst),
    .lineValid(lineValid), .lineNum(lineNum), .lineData(lineData),
    .lineFrameErr(lineFrameErr), .lineParityErr(lineParityErr),
    .lineBreak(lineBreak),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn),
    .headEntry(headEntry), .count(count), .empty(empty), .full(full),
    .strb(strb), .wrEntry(wrEntry), .regRdData(regRdData), .rxIrq(rxIrq)
  );

  silo_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst(rst),
    .strb(strb), .wrEntry(wrEntry), .headEntry(headEntry),
    .count(count), .empty(empty), .full(full)
  );

endmodule

// File: tb/sim_mux_rx_silo.sv
module sim_mux_rx_silo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineValid = 1'b0;
  logic [2:0]  lineNum = '0;
  logic [7:0]  lineData = '0;
  logic        lineFrameErr = 1'b0;
  logic        lineParityErr = 1'b0;
  logic        lineBreak = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        rxIrq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mux_rx_silo u0 (
    .clk(clk), .rst(rst), .lineValid(lineValid), .lineNum(lineNum),
    .lineData(lineData), .lineFrameErr(lineFrameErr),
    .lineParityErr(lineParityErr), .lineBreak(lineBreak),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .rxIrq(rxIrq)
  );

  // {brk, fe, pe, line[2:0], data[7:0], expectedWord[15:0]}
  localparam int NVEC = 8;
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 8'h41, 16'h8041},
    {1'b0, 1'b0, 1'b0, 3'd7, 8'hFF, 16'h87FF},
    {1'b0, 1'b0, 1'b1, 3'd3, 8'h12, 16'h9312},
    {1'b0, 1'b1, 1'b0, 3'd5, 8'h00, 16'hA500},
    {1'b0, 1'b1, 1'b1, 3'd2, 8'hC3, 16'hB2C3},
    {1'b1, 1'b0, 1'b0, 3'd6, 8'h7A, 16'hA600},
    {1'b1, 1'b0, 1'b1, 3'd1, 8'h33, 16'hB100},
    {1'b0, 1'b0, 1'b0, 3'd4, 8'h80, 16'h8480}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic pushChar(input logic [2:0] ln, input logic [7:0] d,
                          input logic fe, input logic pe, input logic brk);
    lineNum = ln; lineData = d; lineFrameErr = fe; lineParityErr = pe;
    lineBreak = brk; lineValid = 1'b1;
    @(negedge clk);
    lineValid = 1'b0; lineBreak = 1'b0; lineFrameErr = 1'b0; lineParityErr = 1'b0;
  endtask

  task automatic hostRead(input logic sel, output logic [15:0] word);
    regSel = sel; regRdEn = 1'b1;
    #1 word = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic hostWrite(input logic sel, input logic [2:0] val);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sampleIrq(input string tag, input logic exp);
    #1 check(tag, {15'd0, rxIrq}, {15'd0, exp});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    sampleIrq("R1 irq after reset", 1'b0);
    hostRead(1'b1, w); check("R1 rx word after reset", w, 16'h0000);
    hostRead(1'b0, w); check("R1 control after reset", w, 16'h0000);

    // R2/R3/R4: vector table walk
    hostWrite(1'b0, 3'b001);
    for (int i = 0; i < NVEC; i++)
      pushChar(VEC[i][26:24], VEC[i][23:16], VEC[i][28], VEC[i][27], VEC[i][29]);
    sampleIrq("R8 irq with enable clear", 1'b0);
    hostWrite(1'b0, 3'b011);
    sampleIrq("R8 irq enabled with data", 1'b1);
    for (int i = 0; i < NVEC; i++) begin
      hostRead(1'b1, w);
      check($sformatf("R2 R3 R4 vector %0d", i), w, VEC[i][15:0]);
    end
    hostRead(1'b1, w); check("R5 empty after drain", w, 16'h0000);
    sampleIrq("R8 irq drops when empty", 1'b0);

    // R5: empty read has no side effect
    hostRead(1'b1, w);
    pushChar(3'd1, 8'h5A, 1'b0, 1'b0, 1'b0);
    hostRead(1'b1, w); check("R5 push after empty read", w, 16'h815A);
    hostRead(1'b1, w); check("R5 single pop per read", w, 16'h0000);

    // R10: control readback and receive-word writes
    hostWrite(1'b0, 3'b101);
    hostRead(1'b0, w); check("R10 control readback", w, 16'h0005);
    hostWrite(1'b1, 3'b010);
    hostRead(1'b0, w); check("R10 rx write leaves control", w, 16'h0005);
    hostRead(1'b1, w); check("R10 rx write leaves queue", w, 16'h0000);

    // R7: scan disabled
    hostWrite(1'b0, 3'b010);
    for (int i = 0; i < 3; i++) pushChar(3'(i), 8'(8'h20 + i), 1'b0, 1'b0, 1'b0);
    sampleIrq("R7 irq with scan off", 1'b0);
    hostRead(1'b1, w); check("R7 nothing stored with scan off", w, 16'h0000);

    // R9: alarm threshold
    hostWrite(1'b0, 3'b111);
    for (int i = 0; i < 15; i++) pushChar(3'(i % 8), 8'(i), 1'b0, 1'b0, 1'b0);
    sampleIrq("R9 irq below alarm level", 1'b0);
    pushChar(3'd7, 8'd15, 1'b0, 1'b0, 1'b0);
    sampleIrq("R9 irq at alarm level", 1'b1);
    hostRead(1'b1, w); check("R9 first alarm entry", w, 16'h8000);
    sampleIrq("R9 irq one below level", 1'b0);
    for (int i = 1; i < 16; i++) begin
      hostRead(1'b1, w);
      check("R2 alarm drain order", w, {1'b1, 4'b0000, 3'(i % 8), 8'(i)});
    end
    hostRead(1'b1, w); check("R5 empty after alarm drain", w, 16'h0000);

    // R6: overflow and overrun mark
    hostWrite(1'b0, 3'b001);
    for (int i = 0; i < 64; i++) pushChar(3'(i % 8), 8'(i), 1'b0, 1'b0, 1'b0);
    pushChar(3'd3, 8'hEE, 1'b0, 1'b0, 1'b0);
    hostRead(1'b1, w); check("R6 first entry unmarked", w, 16'h8000);
    pushChar(3'd2, 8'h55, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i < 64; i++) begin
      hostRead(1'b1, w);
      check("R6 full queue order", w, {1'b1, 4'b0000, 3'(i % 8), 8'(i)});
    end
    hostRead(1'b1, w); check("R6 overrun marked entry", w, 16'hC255);
    hostRead(1'b1, w); check("R6 dropped char absent", w, 16'h0000);
    pushChar(3'd4, 8'h11, 1'b0, 1'b0, 1'b0);
    hostRead(1'b1, w); check("R6 mark cleared afterwards", w, 16'h8411);

    // R1: reset mid-traffic
    hostWrite(1'b0, 3'b011);
    pushChar(3'd0, 8'h99, 1'b0, 1'b0, 1'b0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    sampleIrq("R1 irq after second reset", 1'b0);
    hostRead(1'b0, w); check("R1 control cleared by reset", w, 16'h0000);
    hostRead(1'b1, w); check("R1 queue emptied by reset", w, 16'h0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule